// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt events from peripherals into a 16-bit pending register and gates them with a 16-bit enable register. It drives one request line to the processor. Peripherals raise pending bits through one set pulse per source. A dedicated level input from a DMA engine raises pending bit 3 only on its rising edge.

Software reads both registers and writes them over a small register bus. Writing the pending register acknowledges events. The new pending value is the old pending value ANDed with the enable register and with the written data. So a 0 in the data clears a bit, and so does a disabled enable bit. Two configuration inputs can hold pending bit 7 and pending bit 9 at 1. These forced bits are loaded at reset and merged in again just before every acknowledge.

The request output is registered. It is recomputed from the values the registers take on the same clock edge, so it follows any register change without lag.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the enable register clears to 0x0000, `irq_req` goes low, and the pending register loads only the forced bits (bit 7 if `cfg_force_ser`, bit 9 if `cfg_force_snd`).
- R2: A 1 on `src_set[i]` at a clock edge sets pending bit i. The bit stays set until an acknowledge clears it.
- R3: A write to offset 0x070 loads the pending register with (pending OR forced) AND enable AND `bus_wdata[15:0]`.
- R4: During an acknowledge, the forced bits are merged in before the AND. A forced bit therefore survives when both its enable bit and its data bit are 1, and is cleared otherwise.
- R5: When a set pulse and an acknowledge that clears the same bit arrive at the same edge, the bit ends up set.
- R6: A write to offset 0x074 loads the enable register with `bus_wdata[15:0]`. Reading 0x070 returns the pending register and reading 0x074 returns the enable register.
- R7: After every clock edge, `irq_req` is 1 exactly when pending AND enable is nonzero. This includes the edge at which an enable write unmasks an already pending bit.
- R8: A rising edge on `dma_irq_lvl` sets pending bit 3 once. Holding the level high does not set the bit again after it has been acknowledged.
- R9: `bus_wdata[31:16]` is ignored, and `bus_rdata[31:16]` always reads 0. Reads of any other offset return 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_force_ser | input | 1 | Holds pending bit 7 forced |
| cfg_force_snd | input | 1 | Holds pending bit 9 forced |
| src_set | input | 16 | Per-source set pulses |
| dma_irq_lvl | input | 1 | DMA master interrupt level; its rising edge sets bit 3 |
| bus_addr | input | 12 | Register offset within the I/O page |
| bus_wdata | input | 32 | Write data; only the low 16 bits are used |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Combinational read data |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The acknowledge path is driven with data words in which cleared bits overlap the enable mask in different ways. Those results tell a plain write-1-to-clear or write-data load apart from the three-way AND. Runs with the forced configuration on and off show whether the forced bits are merged before or after masking. A set pulse coinciding with an acknowledge separates set-wins priority from acknowledge-wins priority. A DMA level that is held high and then pulsed again shows edge detection against level sensitivity. Enable writes over already pending bits show whether the request follows the same edge or lags by one cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W    = 16;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 12;
  localparam logic [ADDR_W-1:0] PEND_OFF = 12'h070;
  localparam logic [ADDR_W-1:0] ENAB_OFF = 12'h074;
  localparam int SER_BIT  = 7;
  localparam int SND_BIT  = 9;
  localparam int DMA_BIT  = 3;
endpackage

// File: rtl/intc_edge.sv
module intc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end
  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int W       = intc_pkg::REG_W,
  parameter int SER_POS = intc_pkg::SER_BIT,
  parameter int SND_POS = intc_pkg::SND_BIT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         force_ser,
  input  logic         force_snd,
  input  logic [W-1:0] set_vec,
  input  logic         ack_we,
  input  logic         enab_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] enab_q,
  output logic         irq_q
);
  logic [W-1:0] forced;
  logic [W-1:0] pend_d;
  logic [W-1:0] enab_d;

  always_comb begin
    forced          = '0;
    forced[SER_POS] = force_ser;
    forced[SND_POS] = force_snd;
  end

  always_comb begin
    enab_d = enab_we ? wdata : enab_q;
    if (ack_we) pend_d = ((pend_q | forced) & enab_q & wdata) | set_vec;
    else        pend_d = pend_q | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= forced;
      enab_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      enab_q <= enab_d;
      irq_q  <= |(pend_d & enab_d);
    end
  end
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux #(
  parameter int W  = intc_pkg::REG_W,
  parameter int BW = intc_pkg::BUS_W,
  parameter int AW = intc_pkg::ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  pend,
  input  logic [W-1:0]  enab,
  output logic [BW-1:0] rdata
);
  localparam int PAD = BW - W;
  always_comb begin
    if (addr == intc_pkg::PEND_OFF)      rdata = {{PAD{1'b0}}, pend};
    else if (addr == intc_pkg::ENAB_OFF) rdata = {{PAD{1'b0}}, enab};
    else                                 rdata = '0;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int W  = intc_pkg::REG_W,
  parameter int BW = intc_pkg::BUS_W,
  parameter int AW = intc_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_force_ser,
  input  logic          cfg_force_snd,
  input  logic [W-1:0]  src_set,
  input  logic          dma_irq_lvl,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [BW-1:0] bus_rdata,
  output logic          irq_req
);
  logic         dma_rise;
  logic [W-1:0] set_all;
  logic [W-1:0] pend_q;
  logic [W-1:0] enab_q;
  logic         ack_we;
  logic         enab_we;

  assign ack_we  = bus_we && (bus_addr == intc_pkg::PEND_OFF);
  assign enab_we = bus_we && (bus_addr == intc_pkg::ENAB_OFF);

  intc_edge u_dma_edge (.clk(clk), .rst(rst), .lvl(dma_irq_lvl), .rise(dma_rise));

  always_comb begin
    set_all = src_set;
    set_all[intc_pkg::DMA_BIT] = src_set[intc_pkg::DMA_BIT] | dma_rise;
  end

  intc_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst),
    .force_ser(cfg_force_ser), .force_snd(cfg_force_snd),
    .set_vec(set_all), .ack_we(ack_we), .enab_we(enab_we),
    .wdata(bus_wdata[W-1:0]),
    .pend_q(pend_q), .enab_q(enab_q), .irq_q(irq_req)
  );

  intc_rdmux #(.W(W), .BW(BW), .AW(AW)) u_rd (
    .addr(bus_addr), .pend(pend_q), .enab(enab_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int W  = intc_pkg::REG_W,
  parameter int BW = intc_pkg::BUS_W,
  parameter int AW = intc_pkg::ADDR_W
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_force_ser,
  input logic          cfg_force_snd,
  input logic [W-1:0]  src_set,
  input logic          dma_irq_lvl,
  input logic [AW-1:0] bus_addr,
  input logic [BW-1:0] bus_wdata,
  input logic          bus_we,
  input logic [BW-1:0] bus_rdata,
  input logic          irq_req,
  input logic [W-1:0]  pend,
  input logic [W-1:0]  enab
);
  logic [W-1:0] frc;
  always_comb begin
    frc = '0;
    frc[intc_pkg::SER_BIT] = cfg_force_ser;
    frc[intc_pkg::SND_BIT] = cfg_force_snd;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (enab == '0 && !irq_req));
  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst) irq_req == |(pend & enab));
  // R2
  set_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|src_set) |=> ((pend & $past(src_set)) == $past(src_set)));
  // R6
  enab_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == intc_pkg::ENAB_OFF) |=> enab == $past(bus_wdata[W-1:0]));
  // R3
  ack_and_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == intc_pkg::PEND_OFF && src_set == '0 && !dma_irq_lvl)
    |=> pend == ($past(pend | frc) & $past(enab) & $past(bus_wdata[W-1:0])));
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst) bus_rdata[BW-1:W] == '0);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_force_ser(cfg_force_ser), .cfg_force_snd(cfg_force_snd),
  .src_set(src_set), .dma_irq_lvl(dma_irq_lvl), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_req(irq_req),
  .pend(pend_q), .enab(enab_q)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_force_ser = 1'b1;
  logic        cfg_force_snd = 1'b0;
  logic [15:0] src_set = '0;
  logic        dma_irq_lvl = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [11:0] PEND = 12'h070;
  localparam logic [11:0] ENAB = 12'h074;

  always #10 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst(rst), .cfg_force_ser(cfg_force_ser), .cfg_force_snd(cfg_force_snd),
    .src_set(src_set), .dma_irq_lvl(dma_irq_lvl), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write cycle; returns at the following negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic clear_all();
    cfg_force_ser = 1'b0; cfg_force_snd = 1'b0;
    wr(ENAB, 32'h0000_FFFF);
    wr(PEND, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(PEND, v); chk("R1 pending after reset holds forced bit 7", v, 32'h0080);
    rd(ENAB, v); chk("R1 enable after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_set_and_mask();
    logic [31:0] v;
    src_set = 16'h0011; @(negedge clk); src_set = '0;
    rd(PEND, v); chk("R2 set pulses sticky", v, 32'h0091);
    chk("R7 irq low while masked", {31'b0, irq_req}, 32'h0);
    wr(ENAB, 32'h0000_0010);
    chk("R7 irq after unmasking pending bit", {31'b0, irq_req}, 32'h1);
    rd(ENAB, v); chk("R6 enable readback", v, 32'h0010);
    wr(ENAB, 32'hFFFF_0002);
    rd(ENAB, v); chk("R9 upper write bits ignored", v, 32'h0002);
    chk("R7 irq drops after masking", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(ENAB, 32'h0000_00FF);
    wr(PEND, 32'h0000_FFEF);
    rd(PEND, v); chk("R3 ack ANDs data, enable, forced", v, 32'h0081);
    wr(ENAB, 32'h0000_0001);
    wr(PEND, 32'h0000_FFFF);
    rd(PEND, v); chk("R3 disabled bits cleared by ack", v, 32'h0001);
    wr(ENAB, 32'h0000_0280);
    wr(PEND, 32'h0000_FFFF);
    rd(PEND, v); chk("R4 forced bit 7 restored on ack", v, 32'h0080);
    cfg_force_snd = 1'b1;
    wr(PEND, 32'h0000_FFFF);
    rd(PEND, v); chk("R4 forced bit 9 restored on ack", v, 32'h0280);
    wr(PEND, 32'h0000_0080);
    rd(PEND, v); chk("R4 forced bit 9 cleared by zero data", v, 32'h0080);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    clear_all();
    src_set = 16'h0044; wr(PEND, 32'h0); src_set = '0;
    rd(PEND, v); chk("R5 set wins over clearing ack", v, 32'h0044);
    chk("R7 irq with enabled pending", {31'b0, irq_req}, 32'h1);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    clear_all();
    dma_irq_lvl = 1'b1; @(negedge clk);
    rd(PEND, v); chk("R8 dma rise sets bit 3", v, 32'h0008);
    wr(PEND, 32'h0);
    repeat (3) @(negedge clk);
    rd(PEND, v); chk("R8 held level does not re-set", v, 32'h0);
    dma_irq_lvl = 1'b0; @(negedge clk);
    dma_irq_lvl = 1'b1; @(negedge clk);
    rd(PEND, v); chk("R8 second rise sets bit 3", v, 32'h0008);
    dma_irq_lvl = 1'b0;
  endtask

  task automatic t_other_offset();
    logic [31:0] v;
    clear_all();
    wr(ENAB, 32'h0000_0003);
    wr(12'h078, 32'hFFFF_FFFF);
    wr(12'h072, 32'h0);
    rd(ENAB, v); chk("R9 stray writes leave enable", v, 32'h0003);
    rd(12'h078, v); chk("R9 unmapped read is zero", v, 32'h0);
    src_set = 16'h8000; @(negedge clk); src_set = '0;
    rd(PEND, v); chk("R9 upper read half zero", v & 32'hFFFF_0000, 32'h0);
    chk("R2 bit 15 set", v, 32'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_and_mask();
    t_ack();
    t_prio();
    t_dma();
    t_other_offset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule